// File: doc/BRIEF.md
# Page-Granular Memory Map Decoder

This block sits between a 6502 CPU socket and the memory of the machine around it. Every CPU address is looked up in a small writable attribute table. The table is indexed by the page number, which is the upper eight address bits, so each entry covers 256 bytes. For each page, the entry decides three things: whether the access is served by onboard replacement RAM, whether it is passed through to the motherboard, and whether writes are blocked. A fourth attribute bit drives a spare select output.

A supervising controller holds the CPU and loads the table through a configuration port. It can then override only the regions it needs, for example the zero and stack pages, or only the page that holds the reset vector, and leave the rest of the machine reachable. After reset every page passes through with no write protection, so the host machine behaves as if the block were absent.

The lookup from address to selects is purely combinational, so the selects are settled before phi2 rises. Only table updates are clocked.

Top module: `page_map_decoder`

## Requirements
- R1: After reset, every page reads as passthrough: `mb_pass_o`=1, `onboard_sel_o`=0, `spare_sel_o`=0, and writes are not protected.
- R2: The page is `cpu_addr_i[15:8]`. The low eight address bits have no effect on any select.
- R3: Attribute bit 0 set drives `onboard_sel_o` high for accesses to that page.
- R4: Attribute bit 1 set drives `mb_pass_o` high. When bits 0 and 1 are both set, `onboard_sel_o` is 1 and `mb_pass_o` is 0, and the two outputs are never high together.
- R5: Attribute bit 2 set suppresses `wr_strobe_o` for that page. The page's selects still work for reads and writes.
- R6: `wr_strobe_o` is 1 exactly when `cpu_rw_i`=0, `phi2_i`=1 and the page's bit 2 is clear.
- R7: Attribute bit 3 drives `spare_sel_o`, independently of the other bits.
- R8: A configuration write (`cfg_we_i`=1) changes the table only while `hold_i`=1. With `hold_i`=0 it is ignored.
- R9: A held configuration write stores `cfg_data_i` into entry `cfg_page_i` at the next rising `clk_i`. The outputs follow the new entry combinationally after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for table updates |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | CPU address bus |
| cpu_rw_i | input | 1 | CPU read/write, 1 = read |
| phi2_i | input | 1 | CPU phase-2 clock |
| hold_i | input | 1 | CPU held by supervisor; enables configuration |
| cfg_page_i | input | 8 | Page index for configuration write |
| cfg_data_i | input | 4 | Attribute value for configuration write |
| cfg_we_i | input | 1 | Configuration write enable |
| onboard_sel_o | output | 1 | Select onboard replacement RAM |
| mb_pass_o | output | 1 | Enable passthrough to motherboard |
| wr_strobe_o | output | 1 | Gated write strobe |
| spare_sel_o | output | 1 | Spare select |

## Verification
The bench targets four kinds of mistake.

- **Both target bits set.** A decoder without priority would drive the onboard select and passthrough together and cause bus contention.
- **Page boundaries.** Addresses 0x00FF and 0x0100 fall in different pages. A lookup that indexed on the wrong address bits would give both the same attributes.
- **Write protection.** The protect bit is checked on reads as well as writes. A design that gated the selects instead of the strobe would lose read access to protected pages, and one that ignored the bit would let writes corrupt them.
- **Configuration while the CPU runs.** A configuration write is issued with hold released. If the design still applied it, the remap would show up on the outputs afterwards.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
  localparam int ATTR_W = 4;
  localparam int BIT_ONB = 0;
  localparam int BIT_PASS = 1;
  localparam int BIT_WP = 2;
  localparam int BIT_SPARE = 3;
  // reset value: passthrough only
  localparam logic [ATTR_W-1:0] ATTR_RESET = 4'b0010;

  typedef struct packed {
    logic onboard;
    logic pass;
    logic wstrobe;
    logic spare;
  } sel_t;
endpackage

// File: rtl/pmap_table.sv
module pmap_table
  import pmap_pkg::*;
#(
  parameter int PAGE_W = 8,
  localparam int PAGES = 1 << PAGE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [PAGE_W-1:0]       waddr_i,
  input  logic [ATTR_W-1:0]       wdata_i,
  input  logic [PAGE_W-1:0]       raddr_i,
  output logic [ATTR_W-1:0]       rdata_o,
  output logic [PAGES*ATTR_W-1:0] mem_o
);
  logic [PAGES*ATTR_W-1:0] mem_q;

  for (genvar g = 0; g < PAGES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[g*ATTR_W +: ATTR_W] <= ATTR_RESET;
      else if (we_i && (waddr_i == PAGE_W'(g)))
        mem_q[g*ATTR_W +: ATTR_W] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[int'(raddr_i)*ATTR_W +: ATTR_W];
  assign mem_o   = mem_q;
endmodule

// File: rtl/pmap_decode.sv
module pmap_decode
  import pmap_pkg::*;
(
  input  logic [ATTR_W-1:0] attr_i,
  input  logic              cpu_rw_i,
  input  logic              phi2_i,
  output sel_t              sel_o
);
  always_comb begin
    sel_o.onboard = attr_i[BIT_ONB];
    // onboard wins when both target bits are set
    sel_o.pass    = attr_i[BIT_PASS] & ~attr_i[BIT_ONB];
    sel_o.wstrobe = ~cpu_rw_i & phi2_i & ~attr_i[BIT_WP];
    sel_o.spare   = attr_i[BIT_SPARE];
  end
endmodule

// File: rtl/page_map_decoder.sv
module page_map_decoder
  import pmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  localparam int PAGES = 1 << PAGE_W,
  localparam int OFF_W = ADDR_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_rw_i,
  input  logic              phi2_i,
  input  logic              hold_i,
  input  logic [PAGE_W-1:0] cfg_page_i,
  input  logic [ATTR_W-1:0] cfg_data_i,
  input  logic              cfg_we_i,
  output logic              onboard_sel_o,
  output logic              mb_pass_o,
  output logic              wr_strobe_o,
  output logic              spare_sel_o
);
  logic [PAGE_W-1:0]       page;
  logic [ATTR_W-1:0]       attr;
  logic [PAGES*ATTR_W-1:0] tbl;
  logic                    tbl_we;
  sel_t                    sel;

  assign page   = cpu_addr_i[ADDR_W-1 -: PAGE_W];
  assign tbl_we = cfg_we_i & hold_i;

  pmap_table #(.PAGE_W(PAGE_W)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we),
    .waddr_i (cfg_page_i),
    .wdata_i (cfg_data_i),
    .raddr_i (page),
    .rdata_o (attr),
    .mem_o   (tbl)
  );

  pmap_decode u_decode (
    .attr_i   (attr),
    .cpu_rw_i (cpu_rw_i),
    .phi2_i   (phi2_i),
    .sel_o    (sel)
  );

  assign onboard_sel_o = sel.onboard;
  assign mb_pass_o     = sel.pass;
  assign wr_strobe_o   = sel.wstrobe;
  assign spare_sel_o   = sel.spare;

  AST_SEL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(onboard_sel_o && mb_pass_o)); // R4
  AST_WP_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attr[BIT_WP] |-> !wr_strobe_o); // R5
  AST_STROBE_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |-> (!cpu_rw_i && phi2_i)); // R6
  AST_HOLD_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i |=> $stable(tbl)); // R8
  AST_CFG_APPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && cfg_we_i) |=>
      tbl[int'($past(cfg_page_i))*ATTR_W +: ATTR_W] == $past(cfg_data_i)); // R9
endmodule

// File: tb/tb_page_map_decoder.sv
`timescale 1ns/1ps
module tb_page_map_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rw = 1'b1;
  logic        phi2 = 1'b0;
  logic        hold = 1'b0;
  logic [7:0]  cpage = '0;
  logic [3:0]  cdata = '0;
  logic        cwe = 1'b0;
  logic        onb, pass, wstb, spare;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  page_map_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(addr), .cpu_rw_i(rw),
    .phi2_i(phi2), .hold_i(hold), .cfg_page_i(cpage), .cfg_data_i(cdata),
    .cfg_we_i(cwe), .onboard_sel_o(onb), .mb_pass_o(pass),
    .wr_strobe_o(wstb), .spare_sel_o(spare)
  );

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // outputs packed as {spare, strobe, pass, onboard}
  task automatic probe(input logic [15:0] a, input logic r, input logic p,
                       input string req, input logic [3:0] exp);
    @(negedge clk);
    addr = a; rw = r; phi2 = p;
    #1;
    chk(req, {spare, wstb, pass, onb}, exp);
  endtask

  task automatic cfg(input logic [7:0] pg, input logic [3:0] d, input logic h);
    @(negedge clk);
    hold = h; cpage = pg; cdata = d; cwe = 1'b1;
    @(negedge clk);
    cwe = 1'b0; hold = 1'b0;
  endtask

  task automatic t_reset;
    probe(16'h0000, 1'b1, 1'b1, "R1 page00 read", 4'b0010);
    probe(16'h7F80, 1'b1, 1'b1, "R1 page7F read", 4'b0010);
    probe(16'hFFFC, 1'b0, 1'b1, "R1 pageFF write", 4'b0110);
    probe(16'hA000, 1'b0, 1'b1, "R1 pageA0 write", 4'b0110);
  endtask

  task automatic t_onboard;
    cfg(8'h00, 4'b0001, 1'b1);
    probe(16'h0012, 1'b1, 1'b1, "R3 page00 onboard", 4'b0001);
    probe(16'h0150, 1'b1, 1'b1, "R3 page01 untouched", 4'b0010);
  endtask

  task automatic t_index;
    probe(16'h00FF, 1'b1, 1'b1, "R2 top of page00", 4'b0001);
    probe(16'h0100, 1'b1, 1'b1, "R2 base of page01", 4'b0010);
    probe(16'h0000, 1'b1, 1'b1, "R2 base of page00", 4'b0001);
  endtask

  task automatic t_priority;
    cfg(8'h02, 4'b0011, 1'b1);
    probe(16'h0234, 1'b1, 1'b1, "R4 both bits -> onboard", 4'b0001);
    cfg(8'h03, 4'b0000, 1'b1);
    probe(16'h0300, 1'b1, 1'b1, "R4 neither bit", 4'b0000);
  endtask

  task automatic t_wp;
    cfg(8'hFF, 4'b0110, 1'b1);
    probe(16'hFFFC, 1'b1, 1'b1, "R5 protected read", 4'b0010);
    probe(16'hFFFC, 1'b0, 1'b1, "R5 protected write", 4'b0010);
    probe(16'hFEFF, 1'b0, 1'b1, "R5 neighbour write", 4'b0110);
    cfg(8'h05, 4'b0101, 1'b1);
    probe(16'h0500, 1'b0, 1'b1, "R5 protected onboard write", 4'b0001);
  endtask

  task automatic t_strobe;
    probe(16'h1000, 1'b0, 1'b0, "R6 write phi2 low", 4'b0010);
    probe(16'h1000, 1'b1, 1'b1, "R6 read phi2 high", 4'b0010);
    probe(16'h1000, 1'b0, 1'b1, "R6 write phi2 high", 4'b0110);
    probe(16'h1000, 1'b1, 1'b0, "R6 read phi2 low", 4'b0010);
  endtask

  task automatic t_spare;
    cfg(8'h40, 4'b1000, 1'b1);
    probe(16'h4000, 1'b1, 1'b1, "R7 spare alone", 4'b1000);
    cfg(8'h41, 4'b1011, 1'b1);
    probe(16'h41AA, 1'b1, 1'b1, "R7 spare with onboard", 4'b1001);
  endtask

  task automatic t_hold;
    cfg(8'h10, 4'b0001, 1'b0);
    probe(16'h1000, 1'b1, 1'b1, "R8 write without hold ignored", 4'b0010);
    cfg(8'h00, 4'b0010, 1'b0);
    probe(16'h0000, 1'b1, 1'b1, "R8 remap without hold ignored", 4'b0001);
  endtask

  task automatic t_timing;
    @(negedge clk);
    addr = 16'h2000; rw = 1'b1; phi2 = 1'b1;
    hold = 1'b1; cpage = 8'h20; cdata = 4'b1001; cwe = 1'b1;
    #1;
    chk("R9 before edge", {spare, wstb, pass, onb}, 4'b0010);
    @(posedge clk);
    #1;
    chk("R9 after edge", {spare, wstb, pass, onb}, 4'b1001);
    cwe = 1'b0; hold = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_onboard;
    t_index;
    t_priority;
    t_wp;
    t_strobe;
    t_spare;
    t_hold;
    t_timing;
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule